// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences one DMA channel. Software loads a working source address, destination address and unit count through a small write port, along with backup copies of all three. Static control inputs then select how the addresses move, the unit size, the request source and the restart behaviour. Each unit transfer appears on a request/acknowledge handshake that carries the two addresses. The data path itself lies outside this block. After each acknowledged unit, the count and addresses advance.

When the count runs out, an end flag is set. In repeat mode, the count and addresses are restored from the backups. In reload mode, a short period counter, seeded from the low byte of the backup count, restores the addresses each time it runs out and then reseeds itself from the high byte. A half-way flag can also be set when the count passes half of the backup count. Both flags can drive a level interrupt output. A launch is gated by the channel and master enables and by the error and NMI flags.

Top module: `dma_chan_seq`

## Requirements
- R1: A new unit transfer is launched only when `ch_en` and `master_en` are 1, `addr_err` and `nmi_flag` are 0, the count is not zero and a request is present. The end flag must be 0, unless `repeat_en`=1, `half_int_en`=1 and the half flag is 0.
- R2: Raising `nmi_flag` or `addr_err`, or dropping either enable, lets a unit already on the bus complete, and no further unit is launched.
- R3: `bus_req` stays high with stable `bus_src`/`bus_dst` until `bus_ack`. Each cycle in which both are high completes exactly one unit, and `bus_req` then falls.
- R4: After each unit, each address moves by its mode: 0 fixed, 1 increment, 2 decrement. The step is given by `unit_size`: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes.
- R5: Each unit decrements the count by one. When it reaches 0, `te_flag` is set, and `irq` is high while `te_flag`=1 and `int_en`=1.
- R6: With `repeat_en`=1, the unit that takes the count to 0 also sets `te_flag`, restores the count from the backup count, and restores both addresses from the backup addresses.
- R7: With `half_int_en`=1, a unit that leaves the count equal to the backup count shifted right by one sets `he_flag`. `irq` is high while `he_flag`=1 and `half_int_en`=1.
- R8: With `reload_en`=1, a period counter seeded from backup-count bits 7:0 decrements on each unit. When it reaches 0, both addresses are restored from their backups and the counter is reseeded from backup-count bits 23:16. The main count keeps decrementing.
- R9: `req_mode` 0 requests continuously. Mode 1 uses the synchronized `dreq` level. Mode 2 latches a rising edge of synchronized `dreq` and drops it when the unit it started is acknowledged.
- R10: `te_clr` and `he_clr` clear their flags. A flag set in the same cycle as its clear stays set.
- R11: After reset, `bus_req`, `te_flag`, `he_flag` and `irq` are 0 and the count is 0.
- R12: `cfg_we` writes `cfg_wdata` to the register chosen by `cfg_sel`: 0 source, 1 destination, 2 count, 3 backup source, 4 backup destination, 5 backup count (which also seeds the R8 period counter).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Write data |
| ch_en | input | 1 | Channel enable |
| master_en | input | 1 | Master enable for all channels |
| addr_err | input | 1 | Address error flag |
| nmi_flag | input | 1 | NMI flag |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| unit_size | input | 2 | Transfer unit size code |
| repeat_en | input | 1 | Repeat operation |
| reload_en | input | 1 | Reload operation |
| req_mode | input | 2 | Request source select |
| int_en | input | 1 | End interrupt enable |
| half_int_en | input | 1 | Half-way interrupt enable |
| te_clr | input | 1 | Clear end flag |
| he_clr | input | 1 | Clear half flag |
| dreq | input | 1 | External request, asynchronous |
| bus_req | output | 1 | Unit transfer request |
| bus_src | output | 32 | Source address of the unit |
| bus_dst | output | 32 | Destination address of the unit |
| bus_ack | input | 1 | Unit transfer acknowledge |
| te_flag | output | 1 | End flag |
| he_flag | output | 1 | Half-way flag |
| irq | output | 1 | Interrupt request level |
| cur_count | output | 24 | Current unit count |

## Verification
The acknowledge that takes the count to zero can land in the same cycle as a software clear of the end flag. The two then compete for one flip-flop. The bench provokes this by driving `bus_ack` by hand together with `te_clr` on the single unit of a one-unit run. The result is judged correct when `te_flag` is still 1 on the next cycle and the count reads 0. A second case combines the repeat restore with the half flag: the bench checks that the restored count and addresses are in place when the flag blocks the next launch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2} addr_mode_e;
  typedef enum logic [1:0] {RQ_AUTO = 2'd0, RQ_LEVEL = 2'd1, RQ_EDGE = 2'd2} req_mode_e;
  typedef enum logic [2:0] {
    SEL_SRC = 3'd0, SEL_DST = 3'd1, SEL_CNT = 3'd2,
    SEL_SRC_BK = 3'd3, SEL_DST_BK = 3'd4, SEL_CNT_BK = 3'd5
  } cfg_sel_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_e;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq,
  input  logic [1:0] req_mode,
  input  logic       xfer_done,
  output logic       req_valid
);
  import dma_seq_pkg::*;

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            pend_q;
  logic            synced;
  logic            rise;
  logic            edge_mode;

  assign synced    = sync_q[SYNC-1];
  assign rise      = synced & ~prev_q;
  assign edge_mode = (req_mode == RQ_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], dreq};
      prev_q <= synced;
      // a new edge wins over the acknowledge of the previous one
      pend_q <= edge_mode & (rise | (pend_q & ~xfer_done));
    end
  end

  always_comb begin
    case (req_mode)
      RQ_AUTO:  req_valid = 1'b1;
      RQ_LEVEL: req_valid = synced;
      RQ_EDGE:  req_valid = pend_q;
      default:  req_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cur,
  input  logic          wr_bk,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  input  logic          restore,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] bk_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic [1:0] m,
                                              input logic [1:0] s);
    logic [AW-1:0] d;
    d = (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(2) : AW'(4);
    case (m)
      2'd1:    next_addr = a + d;
      2'd2:    next_addr = a - d;
      default: next_addr = a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      bk_q <= '0;
    end else begin
      if (wr_bk) bk_q <= wdata;
      if (wr_cur)       cur <= wdata;
      else if (restore) cur <= bk_q;
      else if (step)    cur <= next_addr(cur, mode, size);
    end
  end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CW  = 24,
  parameter int RLW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic          wr_bk,
  input  logic [CW-1:0] wdata,
  input  logic          done,
  input  logic          repeat_en,
  input  logic          reload_en,
  input  logic          hie,
  input  logic          te_clr,
  input  logic          he_clr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_bk,
  output logic          te,
  output logic          he,
  output logic          end_evt,
  output logic          half_evt,
  output logic          addr_restore
);
  logic [RLW-1:0] per_q;
  logic [RLW-1:0] per_next;
  logic [CW-1:0]  cnt_next;
  logic           per_wrap;

  assign cnt_next     = count - CW'(1);
  assign per_next     = per_q - RLW'(1);
  assign end_evt      = done & (cnt_next == '0);
  assign half_evt     = done & hie & (cnt_next == (count_bk >> 1));
  assign per_wrap     = done & reload_en & (per_next == '0);
  assign addr_restore = (end_evt & repeat_en) | per_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      count_bk <= '0;
      per_q    <= '0;
      te       <= 1'b0;
      he       <= 1'b0;
    end else begin
      if (wr_cnt)    count <= wdata;
      else if (done) count <= (end_evt & repeat_en) ? count_bk : cnt_next;

      if (wr_bk) count_bk <= wdata;

      if (wr_bk)                  per_q <= wdata[RLW-1:0];
      else if (done & reload_en)  per_q <= per_wrap ? count_bk[CW-1 -: RLW] : per_next;

      if (end_evt)     te <= 1'b1;
      else if (te_clr) te <= 1'b0;

      if (half_evt)    he <= 1'b1;
      else if (he_clr) he <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          ch_en,
  input  logic          master_en,
  input  logic          addr_err,
  input  logic          nmi_flag,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    unit_size,
  input  logic          repeat_en,
  input  logic          reload_en,
  input  logic [1:0]    req_mode,
  input  logic          int_en,
  input  logic          half_int_en,
  input  logic          te_clr,
  input  logic          he_clr,
  input  logic          dreq,
  output logic          bus_req,
  output logic [AW-1:0] bus_src,
  output logic [AW-1:0] bus_dst,
  input  logic          bus_ack,
  output logic          te_flag,
  output logic          he_flag,
  output logic          irq,
  output logic [CW-1:0] cur_count
);
  import dma_seq_pkg::*;

  localparam int RLW = CW / 3;

  seq_state_e    state_q;
  logic          req_valid;
  logic          permit;
  logic          flags_ok;
  logic          go;
  logic          xfer_done;
  logic          end_evt;
  logic          half_evt;
  logic          addr_restore;
  logic [CW-1:0] count_bk;
  logic [AW-1:0] cur_addr [2];
  logic [1:0]    mode_arr [2];

  assign xfer_done = (state_q == ST_BUSY) & bus_ack;
  assign permit    = ch_en & master_en & ~addr_err & ~nmi_flag;
  assign flags_ok  = ~te_flag | (repeat_en & half_int_en & ~he_flag);
  assign go        = permit & flags_ok & req_valid & (cur_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (go)      state_q <= ST_BUSY;
        ST_BUSY: if (bus_ack) state_q <= ST_IDLE;
        default:              state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req = (state_q == ST_BUSY);
  assign bus_src = cur_addr[0];
  assign bus_dst = cur_addr[1];
  assign irq     = (te_flag & int_en) | (he_flag & half_int_en);

  dma_req_detect #(.SYNC(SYNC)) u_req (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .req_mode(req_mode),
    .xfer_done(xfer_done), .req_valid(req_valid)
  );

  dma_count_unit #(.CW(CW), .RLW(RLW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_cnt(cfg_we && cfg_sel == SEL_CNT),
    .wr_bk(cfg_we && cfg_sel == SEL_CNT_BK),
    .wdata(cfg_wdata[CW-1:0]),
    .done(xfer_done), .repeat_en(repeat_en), .reload_en(reload_en),
    .hie(half_int_en), .te_clr(te_clr), .he_clr(he_clr),
    .count(cur_count), .count_bk(count_bk), .te(te_flag), .he(he_flag),
    .end_evt(end_evt), .half_evt(half_evt), .addr_restore(addr_restore)
  );

  assign mode_arr[0] = src_mode;
  assign mode_arr[1] = dst_mode;

  for (genvar g = 0; g < 2; g++) begin : g_addr
    localparam logic [2:0] CUR_SEL = (g == 0) ? SEL_SRC : SEL_DST;
    localparam logic [2:0] BK_SEL  = (g == 0) ? SEL_SRC_BK : SEL_DST_BK;
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n),
      .wr_cur(cfg_we && cfg_sel == CUR_SEL),
      .wr_bk(cfg_we && cfg_sel == BK_SEL),
      .wdata(cfg_wdata), .step(xfer_done), .restore(addr_restore),
      .mode(mode_arr[g]), .size(unit_size), .cur(cur_addr[g])
    );
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          ch_en,
  input logic          master_en,
  input logic          addr_err,
  input logic          nmi_flag,
  input logic          repeat_en,
  input logic          te_clr,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [AW-1:0] bus_src,
  input logic [AW-1:0] bus_dst,
  input logic          te_flag,
  input logic [CW-1:0] cur_count,
  input logic [CW-1:0] count_bk,
  input logic          xfer_done,
  input logic          end_evt
);
  a_r1_launch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(ch_en && master_en && !addr_err && !nmi_flag));

  a_r2_no_new_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && (nmi_flag || addr_err || !ch_en || !master_en)) |=> !bus_req);

  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !cfg_we) |=> (bus_req && $stable(bus_src) && $stable(bus_dst)));

  a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !end_evt && !cfg_we) |=> (cur_count == CW'($past(cur_count) - CW'(1))));

  a_r5_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && end_evt) |=> te_flag);

  a_r6_repeat_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && end_evt && repeat_en && !cfg_we) |=> (cur_count == $past(count_bk)));

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && te_clr) |=> te_flag);

  a_r12_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd2) |=> (cur_count == $past(cfg_wdata[CW-1:0])));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .ch_en(ch_en), .master_en(master_en),
  .addr_err(addr_err), .nmi_flag(nmi_flag), .repeat_en(repeat_en),
  .te_clr(te_clr), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_src(bus_src), .bus_dst(bus_dst), .te_flag(te_flag),
  .cur_count(cur_count), .count_bk(count_bk), .xfer_done(xfer_done),
  .end_evt(end_evt)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ch_en = 1'b0, master_en = 1'b0, addr_err = 1'b0, nmi_flag = 1'b0;
  logic [1:0]  src_mode = '0, dst_mode = '0, unit_size = '0, req_mode = '0;
  logic        repeat_en = 1'b0, reload_en = 1'b0, int_en = 1'b0, half_int_en = 1'b0;
  logic        te_clr = 1'b0, he_clr = 1'b0, dreq = 1'b0;
  logic        bus_req;
  logic [31:0] bus_src, bus_dst;
  logic        bus_ack = 1'b0;
  logic        te_flag, he_flag, irq;
  logic [23:0] cur_count;

  int checks = 0;
  int errors = 0;
  int xfers  = 0;
  logic        ack_en = 1'b1;
  logic [31:0] xsrc [256];

  always #5 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ch_en(ch_en), .master_en(master_en), .addr_err(addr_err), .nmi_flag(nmi_flag),
    .src_mode(src_mode), .dst_mode(dst_mode), .unit_size(unit_size),
    .repeat_en(repeat_en), .reload_en(reload_en), .req_mode(req_mode),
    .int_en(int_en), .half_int_en(half_int_en), .te_clr(te_clr), .he_clr(he_clr),
    .dreq(dreq), .bus_req(bus_req), .bus_src(bus_src), .bus_dst(bus_dst),
    .bus_ack(bus_ack), .te_flag(te_flag), .he_flag(he_flag), .irq(irq),
    .cur_count(cur_count)
  );

  // responder: one acknowledge pulse per request, logging the source address
  always @(negedge clk) begin
    if (ack_en) begin
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        xsrc[xfers & 255] <= bus_src;
        xfers <= xfers + 1;
      end else begin
        bus_ack <= 1'b0;
      end
    end
  end

  // {src_mode, dst_mode, unit_size, count, expected src[15:0], expected dst[15:0]}
  localparam logic [45:0] VEC [5] = '{
    {2'd1, 2'd1, 2'd0, 8'd3, 16'h1003, 16'h2003},
    {2'd1, 2'd2, 2'd1, 8'd4, 16'h1008, 16'h1FF8},
    {2'd0, 2'd1, 2'd2, 8'd2, 16'h1000, 16'h2008},
    {2'd2, 2'd0, 2'd2, 8'd5, 16'h0FEC, 16'h2000},
    {2'd2, 2'd2, 2'd0, 8'd1, 16'h0FFF, 16'h1FFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    ch_en = 0; master_en = 0; addr_err = 0; nmi_flag = 0;
    src_mode = 0; dst_mode = 0; unit_size = 0; req_mode = 0;
    repeat_en = 0; reload_en = 0; int_en = 0; half_int_en = 0;
    te_clr = 0; he_clr = 0; dreq = 0;
    settle(2);
    rst_n = 1'b1;
    settle(1);
  endtask

  task automatic pulse_clr(input bit te, input bit he);
    @(negedge clk);
    te_clr = te; he_clr = he;
    @(negedge clk);
    te_clr = 0; he_clr = 0;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int x1;
    // R11 reset state; R1 zero count blocks a launch
    do_reset;
    chk("R11 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R11 te_flag", {31'd0, te_flag}, 32'd0);
    chk("R11 he/irq", {30'd0, he_flag, irq}, 32'd0);
    chk("R11 count", {8'd0, cur_count}, 32'd0);
    ch_en = 1; master_en = 1;
    settle(10);
    chk("R1 zero count no launch", xfers, 0);

    // R4 R5 R12: table of address modes and sizes
    for (int i = 0; i < 5; i++) begin
      do_reset;
      src_mode = VEC[i][45:44]; dst_mode = VEC[i][43:42]; unit_size = VEC[i][41:40];
      wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, {24'd0, VEC[i][39:32]});
      base = xfers;
      ch_en = 1; master_en = 1;
      settle(60);
      chk("R5 unit count", xfers - base, {24'd0, VEC[i][39:32]});
      chk("R5 count zero", {8'd0, cur_count}, 32'd0);
      chk("R5 te_flag", {31'd0, te_flag}, 32'd1);
      chk("R4 src", bus_src, {16'd0, VEC[i][31:16]});
      chk("R4 dst", bus_dst, {16'd0, VEC[i][15:0]});
      chk("R5 irq off", {31'd0, irq}, 32'd0);
    end

    // R1 gating by enables and error flag
    do_reset;
    wr(3'd2, 32'd3);
    base = xfers;
    ch_en = 0; master_en = 1; settle(10);
    master_en = 0; ch_en = 1; settle(10);
    master_en = 1; addr_err = 1; settle(10);
    chk("R1 no launch when gated", xfers - base, 0);
    chk("R1 count held", {8'd0, cur_count}, 32'd3);

    // R3 hold without ack, R2 stop after the unit in flight
    do_reset;
    ack_en = 0;
    src_mode = 1;
    wr(3'd0, 32'h0500); wr(3'd2, 32'd5);
    base = xfers;
    ch_en = 1; master_en = 1;
    settle(8);
    chk("R3 req held", {31'd0, bus_req}, 32'd1);
    chk("R3 addr stable", bus_src, 32'h0500);
    nmi_flag = 1;
    ack_en = 1;
    settle(20);
    chk("R2 one unit completes", xfers - base, 1);
    chk("R2 count", {8'd0, cur_count}, 32'd4);
    chk("R2 req low", {31'd0, bus_req}, 32'd0);

    // R5 interrupt, R10 plain clear
    do_reset;
    int_en = 1;
    wr(3'd2, 32'd2);
    ch_en = 1; master_en = 1;
    settle(30);
    chk("R5 irq on end", {31'd0, irq}, 32'd1);
    pulse_clr(1, 0);
    chk("R10 te cleared", {31'd0, te_flag}, 32'd0);
    chk("R5 irq follows flag", {31'd0, irq}, 32'd0);

    // R6 R7 repeat with half-way flag
    do_reset;
    repeat_en = 1; half_int_en = 1; src_mode = 1; dst_mode = 1;
    wr(3'd0, 32'h0100); wr(3'd3, 32'h0100);
    wr(3'd1, 32'h0200); wr(3'd4, 32'h0200);
    wr(3'd2, 32'd4); wr(3'd5, 32'd4);
    base = xfers;
    ch_en = 1; master_en = 1;
    settle(60);
    chk("R7 stop after end with half set", xfers - base, 4);
    chk("R6 count restored", {8'd0, cur_count}, 32'd4);
    chk("R6 src restored", bus_src, 32'h0100);
    chk("R6 dst restored", bus_dst, 32'h0200);
    chk("R6 te set", {31'd0, te_flag}, 32'd1);
    chk("R7 he irq", {30'd0, he_flag, irq}, 32'd3);
    pulse_clr(0, 1);
    settle(60);
    chk("R7 resumes to next half", xfers - base, 6);
    chk("R7 count at half", {8'd0, cur_count}, 32'd2);
    chk("R6 fifth unit from backup", xsrc[(base + 4) & 255], 32'h0100);

    // R8 reload period: low byte 3, high byte 2
    do_reset;
    reload_en = 1; src_mode = 1; dst_mode = 1;
    wr(3'd0, 32'h0300); wr(3'd3, 32'h0300);
    wr(3'd1, 32'h0400); wr(3'd4, 32'h0400);
    wr(3'd2, 32'd6); wr(3'd5, 32'h0002_0003);
    base = xfers;
    ch_en = 1; master_en = 1;
    settle(60);
    chk("R8 units", xfers - base, 6);
    chk("R8 third unit", xsrc[(base + 2) & 255], 32'h0302);
    chk("R8 restore after low byte", xsrc[(base + 3) & 255], 32'h0300);
    chk("R8 reseed from high byte", xsrc[(base + 5) & 255], 32'h0300);
    chk("R8 final src", bus_src, 32'h0301);
    chk("R8 te", {31'd0, te_flag}, 32'd1);

    // R9 level request
    do_reset;
    req_mode = 1;
    wr(3'd2, 32'd20);
    base = xfers;
    ch_en = 1; master_en = 1;
    settle(20);
    chk("R9 level low idle", xfers - base, 0);
    dreq = 1; settle(10); dreq = 0;
    settle(20);
    x1 = xfers - base;
    chk("R9 level high moves", {31'd0, (x1 > 0 && x1 < 20)}, 32'd1);
    settle(20);
    chk("R9 level low stops", xfers - base, x1);

    // R9 edge request
    do_reset;
    req_mode = 2;
    wr(3'd2, 32'd20);
    base = xfers;
    ch_en = 1; master_en = 1;
    dreq = 1; settle(6); dreq = 0;
    settle(30);
    chk("R9 one edge one unit", xfers - base, 1);
    dreq = 1; settle(6); dreq = 0;
    settle(30);
    chk("R9 second edge", xfers - base, 2);
    chk("R9 count", {8'd0, cur_count}, 32'd18);

    // R10 end flag set and clear in the same cycle
    do_reset;
    ack_en = 0;
    wr(3'd2, 32'd1);
    ch_en = 1; master_en = 1;
    settle(5);
    chk("R10 req up", {31'd0, bus_req}, 32'd1);
    bus_ack = 1; te_clr = 1;
    @(negedge clk);
    bus_ack = 0; te_clr = 0;
    chk("R10 set wins", {31'd0, te_flag}, 32'd1);
    chk("R10 count zero", {8'd0, cur_count}, 32'd0);
    ack_en = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule